// File: doc/BRIEF.md
# Flash Block Lock Sequencer

This block is a host-side controller that locks one or more blocks of a parallel NOR flash device. Block addresses arrive on a valid/ready stream. For each one the sequencer drives the device bus through a lock operation: a setup write, a confirm write, and then status reads until the device's internal controller reports ready. A batch is a run of blocks that ends with the block flagged `blk_last`. When a batch ends, the sequencer puts the device back in read-array mode and raises a one-cycle `done` with a result code.

A mode input picks when the status error bits are examined. In per-operation mode they are decoded after every lock operation, and the first error ends the batch. In deferred mode the device's error bits are allowed to pile up over the whole batch and are decoded once, after the last block. When any error is found, a clear-status write is issued before the read-array write. A poll limit keeps a device that never becomes ready from stalling the sequencer.

Stream rules: `blk_ready` is high only while the sequencer is idle between operations. A block is taken on a clock edge where `blk_valid` and `blk_ready` are both high. While `blk_ready` is low, the source must keep `blk_addr`, `blk_last` and `blk_valid` stable. Blocks left in the source after an error batch form the next batch.

Top module: `blk_lock_seq`

## Requirements
- R1: After reset, `blk_ready` is 1, `bus_we`, `bus_re` and `done` are 0.
- R2: For each accepted block the sequencer writes data 60h and then, in the next cycle, data 01h, both to that block's address.
- R3: After the confirm write, `bus_re` is high for one cycle per read, with reads back to back. Polling stops on the first read where `bus_rdata` bit 7 is 1. The bus never has write and read strobes high in the same cycle.
- R4: The status decode follows a fixed priority. Bit 3 set gives result 1 (voltage). Otherwise, bits 4 and 5 both set give result 2 (sequence). Otherwise, bit 4 set gives result 3 (lock). Otherwise the result is 0 (success).
- R5: In per-operation mode (`defer_check`=0), the status is decoded after every operation. On success the sequencer accepts the next block of the batch. On an error the batch ends at once.
- R6: `defer_check` is sampled only with the first block of a batch. In deferred mode no decode happens until the read that ends polling of the `blk_last` block.
- R7: Whenever the result is nonzero, a write of data 50h comes directly before the read-array write.
- R8: Every batch ends with a write of data FFh to the address of the last block handled. `done` is high for exactly the next cycle, with `result` valid during it.
- R9: If POLL_LIMIT consecutive reads all show bit 7 as 0, polling stops and the result is 4 (timeout).
- R10: `blk_ready` is 0 in every cycle where the sequencer drives a write or read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | Block address available |
| blk_ready | output | 1 | Sequencer can accept a block |
| blk_addr | input | AW | Address of block to lock |
| blk_last | input | 1 | Block ends its batch |
| defer_check | input | 1 | 1 = decode status once per batch |
| bus_addr | output | AW | Device bus address |
| bus_wdata | output | 8 | Device bus write data |
| bus_rdata | input | 8 | Device status, sampled at the edge ending a read cycle |
| bus_we | output | 1 | Write strobe, one cycle per write |
| bus_re | output | 1 | Read strobe, one cycle per read |
| done | output | 1 | One-cycle batch completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 sequence, 3 lock, 4 timeout |

## Verification
A wrong state in this sequencer shows up on the device bus within one or two cycles. Examples are a missing confirm write, a write to the wrong block, or a read-array write with no clear-status write before it when an error is pending. The result code shows the same fault only once the batch ends. For that reason the bench compares every write strobe against a scoreboard as it happens, and it counts status reads so that a poll that stops early or late is caught. Errors injected into the device's accumulated status show whether the decode priority and the mode latch at the start of a batch act at the right operation.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef enum logic [2:0] {
    RES_OK   = 3'd0,
    RES_VOLT = 3'd1,
    RES_SEQ  = 3'd2,
    RES_LOCK = 3'd3,
    RES_TMO  = 3'd4
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CONFIRM, ST_POLL, ST_CLEAR, ST_ARRAY
  } st_e;

  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'h01;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  localparam int RDY_BIT  = 7;
  localparam int VOLT_BIT = 3;
  localparam int LOCK_BIT = 4;
  localparam int SEQ_BIT  = 5;
endpackage

// File: rtl/lock_status_decode.sv
module lock_status_decode
  import blk_lock_pkg::*;
(
  input  logic [7:0] stat,
  output res_e       code
);
  // R4: priority voltage > sequence > lock > success
  always_comb begin
    if (stat[VOLT_BIT])                        code = RES_VOLT;
    else if (stat[LOCK_BIT] && stat[SEQ_BIT])  code = RES_SEQ;
    else if (stat[LOCK_BIT])                   code = RES_LOCK;
    else                                       code = RES_OK;
  end
endmodule

// File: rtl/lock_poll_timer.sv
module lock_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assign expired = tick && (cnt == LAST);

  // R9: counter never runs past the limit while polling
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt <= LAST);
endmodule

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
  import blk_lock_pkg::*;
#(
  parameter int AW         = 16,
  parameter int POLL_LIMIT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_valid,
  output logic          blk_ready,
  input  logic [AW-1:0] blk_addr,
  input  logic          blk_last,
  input  logic          defer_check,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          bus_we,
  output logic          bus_re,
  output logic          done,
  output logic [2:0]    result
);
  st_e           state;
  logic [AW-1:0] addr_q;
  logic          last_q, defer_q, in_batch_q;
  res_e          res_q, res_out_q, dec_code;
  logic          done_q, poll_expired, dev_ready, check_now;

  lock_status_decode u_dec (.stat(bus_rdata), .code(dec_code));

  lock_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_POLL),
    .tick((state == ST_POLL) && !bus_rdata[RDY_BIT]),
    .expired(poll_expired)
  );

  assign dev_ready = bus_rdata[RDY_BIT];
  assign check_now = !defer_q || last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      last_q     <= 1'b0;
      defer_q    <= 1'b0;
      in_batch_q <= 1'b0;
      res_q      <= RES_OK;
      res_out_q  <= RES_OK;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (blk_valid) begin
          addr_q     <= blk_addr;
          last_q     <= blk_last;
          in_batch_q <= 1'b1;
          if (!in_batch_q) defer_q <= defer_check;
          state <= ST_SETUP;
        end
        ST_SETUP:   state <= ST_CONFIRM;
        ST_CONFIRM: state <= ST_POLL;
        ST_POLL: begin
          if (dev_ready) begin
            if (check_now && dec_code != RES_OK) begin
              res_q <= dec_code;
              state <= ST_CLEAR;
            end else if (last_q) begin
              res_q <= RES_OK;
              state <= ST_ARRAY;
            end else begin
              state <= ST_IDLE;
            end
          end else if (poll_expired) begin
            res_q <= RES_TMO;
            state <= ST_CLEAR;
          end
        end
        ST_CLEAR: state <= ST_ARRAY;
        ST_ARRAY: begin
          done_q     <= 1'b1;
          res_out_q  <= res_q;
          in_batch_q <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_we    = 1'b0;
    bus_wdata = 8'h00;
    case (state)
      ST_SETUP:   begin bus_we = 1'b1; bus_wdata = CMD_SETUP;   end
      ST_CONFIRM: begin bus_we = 1'b1; bus_wdata = CMD_CONFIRM; end
      ST_CLEAR:   begin bus_we = 1'b1; bus_wdata = CMD_CLEAR;   end
      ST_ARRAY:   begin bus_we = 1'b1; bus_wdata = CMD_ARRAY;   end
      default:    ;
    endcase
  end

  assign bus_re    = (state == ST_POLL);
  assign bus_addr  = addr_q;
  assign blk_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign result    = res_out_q;

  // R3: write and read strobes never overlap
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R2: setup is followed by confirm to the same address
  assert_confirm_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata == CMD_SETUP) |=>
      (bus_we && bus_wdata == CMD_CONFIRM && $stable(bus_addr)));

  // R7: clear-status is immediately followed by read-array
  assert_clear_then_array_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata == CMD_CLEAR) |=> (bus_we && bus_wdata == CMD_ARRAY));

  // R8: done only in the cycle after a read-array write
  assert_done_after_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata == CMD_ARRAY) |=> done);

  // R10: no stream acceptance while the bus is in use
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) |-> !blk_ready);
endmodule

// File: tb/tb_blk_lock_seq.sv
`timescale 1ns/1ps
module tb_blk_lock_seq;
  localparam int AW = 16;
  localparam int LIM = 64;

  logic clk = 0, rst_n = 0;
  logic blk_valid = 0, blk_last = 0, defer_check = 0;
  logic [AW-1:0] blk_addr = '0;
  logic blk_ready, bus_we, bus_re, done;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [2:0] result;

  always #2.5 clk = ~clk;

  blk_lock_seq #(.AW(AW), .POLL_LIMIT(LIM)) dut (.*);

  // device model: status register with accumulating error bits [5:3]
  int busy_cnt = 0, busy_load = 0;
  logic [2:0] dev_err = 3'b0;
  logic [2:0] inj_q[$];
  assign bus_rdata = {busy_cnt == 0, 1'b0, dev_err, 3'b000};

  always @(posedge clk) begin
    if (bus_we && bus_wdata == 8'h01) begin
      busy_cnt <= busy_load;
      dev_err  <= dev_err | ((inj_q.size() > 0) ? inj_q.pop_front() : 3'b0);
    end else if (bus_we && bus_wdata == 8'h50) begin
      dev_err <= 3'b0;
    end else if (bus_re && busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  int checks = 0, fails = 0, done_seen = 0, rd_cnt = 0;
  logic [AW+7:0] exp_w[$];
  logic [2:0] exp_r[$];
  string tag = "R1";
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (bus_we) begin
      if (exp_w.size() == 0) chk(0, {tag, " R2/R7 unexpected write"}, {bus_addr, bus_wdata}, 0);
      else begin
        logic [AW+7:0] e;
        e = exp_w.pop_front();
        chk({bus_addr, bus_wdata} == e, {tag, " R2/R7/R8 write"}, {bus_addr, bus_wdata}, e);
      end
    end
    if (bus_re) begin
      rd_cnt++;
      if (blk_ready) chk(0, "R10 ready during read", 1, 0);
    end
    if (done) begin
      if (exp_r.size() == 0) chk(0, {tag, " R8 unexpected done"}, result, 0);
      else begin
        logic [2:0] r;
        r = exp_r.pop_front();
        chk(result == r, {tag, " R4/R8 result"}, result, r);
      end
      done_seen++;
    end
  end

  task automatic exp_op(logic [AW-1:0] a);
    exp_w.push_back({a, 8'h60});
    exp_w.push_back({a, 8'h01});
  endtask

  task automatic exp_end(logic [AW-1:0] a, logic [2:0] r);
    if (r != 0) exp_w.push_back({a, 8'h50});
    exp_w.push_back({a, 8'hFF});
    exp_r.push_back(r);
  endtask

  task automatic send(logic [AW-1:0] a, bit last, bit dfr);
    @(negedge clk);
    while (!blk_ready) @(negedge clk);
    blk_valid = 1; blk_addr = a; blk_last = last; defer_check = dfr;
    @(negedge clk);
    blk_valid = 0;
  endtask

  task automatic finish_batch(int n, string req);
    wait (done_seen == n);
    @(negedge clk);
    chk(exp_w.size() == 0, {req, " all writes seen"}, exp_w.size(), 0);
  endtask

  task automatic single(logic [AW-1:0] a, logic [2:0] inj, logic [2:0] r, int n, string t);
    tag = t;
    inj_q.push_back(inj);
    exp_op(a); exp_end(a, r);
    send(a, 1, 0);
    finish_batch(n, t);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(blk_ready == 1 && bus_we == 0 && bus_re == 0 && done == 0, "R1 reset state",
        {blk_ready, bus_we, bus_re, done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(blk_ready == 1, "R1 ready after reset", blk_ready, 1);

    // R2 / R8 basic success
    single(16'h1000, 3'b000, 3'd0, 1, "R2");
    // R4 priority cases (bits [5:3] = seq,lock,volt)
    single(16'h2000, 3'b001, 3'd1, 2, "R4 volt");
    single(16'h2100, 3'b110, 3'd2, 3, "R4 seq");
    single(16'h2200, 3'b010, 3'd3, 4, "R4 lock");
    single(16'h2300, 3'b111, 3'd1, 5, "R4 all");
    single(16'h2400, 3'b100, 3'd0, 6, "R4 bit5only");

    // R3 busy polling: 5 busy reads then ready => 6 reads
    tag = "R3"; busy_load = 5; rd_cnt = 0;
    inj_q.push_back(3'b000);
    exp_op(16'h3000); exp_end(16'h3000, 0);
    send(16'h3000, 1, 0);
    finish_batch(7, "R3");
    chk(rd_cnt == 6, "R3 poll count", rd_cnt, 6);

    // R9 timeout
    tag = "R9"; busy_load = 1000; rd_cnt = 0;
    inj_q.push_back(3'b000);
    exp_op(16'h4000); exp_end(16'h4000, 4);
    send(16'h4000, 1, 0);
    finish_batch(8, "R9");
    chk(rd_cnt == LIM, "R9 reads before timeout", rd_cnt, LIM);
    busy_load = 0;
    repeat (2) @(negedge clk);

    // R5 per-op batch, all ok: one done at end
    tag = "R5 ok"; busy_load = 2;
    for (int i = 0; i < 3; i++) begin inj_q.push_back(3'b000); exp_op(16'h5000 + 16'(i)); end
    exp_end(16'h5002, 0);
    for (int i = 0; i < 3; i++) send(16'h5000 + 16'(i), i == 2, 0);
    finish_batch(9, "R5 ok");

    // R5 per-op: error on first block ends batch; second block forms new batch
    tag = "R5 err";
    inj_q.push_back(3'b010); inj_q.push_back(3'b000);
    exp_op(16'h5100); exp_end(16'h5100, 3);
    exp_op(16'h5101); exp_end(16'h5101, 0);
    send(16'h5100, 0, 0);
    send(16'h5101, 1, 0);
    finish_batch(11, "R5 err");

    // R6 deferred, mode changed mid batch must be ignored; error on block 0
    tag = "R6"; rd_cnt = 0;
    inj_q.push_back(3'b010); inj_q.push_back(3'b000); inj_q.push_back(3'b000);
    for (int i = 0; i < 3; i++) exp_op(16'h6000 + 16'(i));
    exp_end(16'h6002, 3);
    send(16'h6000, 0, 1);
    send(16'h6001, 0, 0);
    send(16'h6002, 1, 0);
    finish_batch(12, "R6");
    chk(rd_cnt == 9, "R6 reads across batch", rd_cnt, 9);
    chk(dev_err == 3'b000, "R7 status cleared", dev_err, 0);

    repeat (4) @(negedge clk);
    chk(done_seen == 12 && exp_r.size() == 0, "R8 done count", done_seen, 12);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule